// File: doc/BRIEF.md
# Mailbox Response Poller

This block is the requester side of a single-slot shared-memory mailbox. After the requester has written a request, it pulses `start_i` with the message type and version it expects back, and with a flag saying whether the request asked for a function reset. The poller then reads the last word of the mailbox aperture over and over until the owner bit shows the mailbox is back in requester hands. A fixed, parameterised number of idle cycles separates two reads. When ownership returns, the poller validates the response header. It then reports one of four result codes, together with a one-cycle `done_o` pulse.

Each read goes over a valid/ready request channel (`rd_valid_o`/`rd_ready_i`) and comes back on a valid/ready response channel (`rsp_valid_i`/`rsp_ready_o`). A read request is a pending transfer and stays asserted until the memory side takes it. The poller asserts `rsp_ready_o` only while one read is outstanding, so the memory side applies back-pressure simply by delaying `rd_ready_i` or `rsp_valid_i`. Only one read is ever in flight. Request writing and the aperture storage belong to other blocks.

Top module: `mbox_rsp_poller`

## Requirements
- R1: A `start_i` pulse while `busy_o` is low captures `exp_type_i`, `exp_ver_i` and `reset_ok_i`, and raises `busy_o` on the next cycle. A `start_i` pulse while `busy_o` is high has no effect on the running poll or its result.
- R2: Each attempt asserts `rd_valid_o` and holds it until `rd_ready_i` is seen. It then asserts `rsp_ready_o` and holds it until `rsp_valid_i` arrives. The two are never high together, and `rsp_data_i` is ignored unless accepted.
- R3: An accepted word with bit 31 (owner) equal to 0 ends polling, and the header check of R5/R6 is applied to that word.
- R4: When the captured reset flag is set and the accepted word is 0xFFFFFFFF, the poll ends with result 0 (ok) and no header check. With the flag clear, that word counts as still owned (bit 31 set).
- R5: A returned word is a mismatch (result 2) if bits [2:0] differ from the expected type, if bits [5:3] exceed the expected version, or if bit 7 (direction) is 0. A lower version than expected is accepted.
- R6: A returned word that passes R5 gives result 3 (operation failed) when its status field, bits [15:8], is nonzero, and result 0 (ok) otherwise.
- R7: After a still-owned word is accepted and attempts remain, `rd_valid_o` stays low for exactly `POLL_GAP` cycles before the next request.
- R8: When the `MAX_POLLS`-th read still shows ownership, the poll ends at once with result 1 (timeout). No further read is issued, so exactly `MAX_POLLS` reads take place.
- R9: `done_o` is high for exactly one cycle, the cycle right after the deciding word is accepted. `busy_o` is low in that cycle, and `result_o` holds its value until the next `done_o`.
- R10: After reset, `busy_o`, `done_o`, `rd_valid_o` and `rsp_ready_o` are 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a poll (accepted only when idle) |
| exp_type_i | input | 3 | Expected response message type |
| exp_ver_i | input | 3 | Highest acceptable response version |
| reset_ok_i | input | 1 | All-ones word counts as success |
| rd_valid_o | output | 1 | Read request for the aperture's last word |
| rd_ready_i | input | 1 | Memory side accepts the read request |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 32 | Read data: the mailbox header word |
| rsp_ready_o | output | 1 | Poller accepts read data |
| busy_o | output | 1 | A poll is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 ok, 1 timeout, 2 mismatch, 3 operation failed |

## Verification
The assertions assume the memory side follows the handshake. It returns exactly one `rsp_valid_i` beat per accepted read and never presents data while no read is outstanding. The read-count and reset-word properties rely on this. The bench's responder model keeps to that rule: it queues one reply per accepted request, waits a random latency of zero to two cycles, and drives the data word at 0xFFFFFFFF whenever `rsp_valid_i` is low, so stale data is never mistaken for a reply. Ready and latency vary at random, and a shortened `MAX_POLLS` and `POLL_GAP` keep timeouts and gaps quick to reach.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

  localparam int WORD_W = 32;
  localparam int TYPE_W = 3;
  localparam int VER_W  = 3;
  localparam int STAT_W = 8;

  typedef enum logic [1:0] {
    RES_OK       = 2'd0,
    RES_TIMEOUT  = 2'd1,
    RES_MISMATCH = 2'd2,
    RES_OPFAIL   = 2'd3
  } mbp_result_e;

  // Header word of the mailbox; bit positions are fixed by the peer.
  typedef struct packed {
    logic              owner;      // 31: 1 = responder holds the slot
    logic [5:0]        rsv_hi;     // 30:25
    logic              rst_req;    // 24
    logic [7:0]        rsv_mid;    // 23:16
    logic [STAT_W-1:0] status;     // 15:8
    logic              is_reply;   // 7
    logic              rsv_lo;     // 6
    logic [VER_W-1:0]  ver;        // 5:3
    logic [TYPE_W-1:0] kind;       // 2:0
  } mbp_hdr_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_GAP   = 2'd3
  } mbp_state_e;

endpackage

// File: rtl/mbp_hdr_check.sv
module mbp_hdr_check
  import mbp_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [TYPE_W-1:0] exp_type_i,
  input  logic [VER_W-1:0]  exp_ver_i,
  output mbp_result_e       verdict_o
);

  mbp_hdr_t hdr;
  logic     kind_bad;
  logic     ver_bad;
  logic     dir_bad;
  logic     stat_bad;

  assign hdr      = mbp_hdr_t'(word_i);
  assign kind_bad = (hdr.kind != exp_type_i);
  assign ver_bad  = (hdr.ver > exp_ver_i);
  assign dir_bad  = !hdr.is_reply;
  assign stat_bad = |hdr.status;

  always_comb begin
    if (kind_bad || ver_bad || dir_bad) begin
      verdict_o = RES_MISMATCH;
    end else if (stat_bad) begin
      verdict_o = RES_OPFAIL;
    end else begin
      verdict_o = RES_OK;
    end
  end

endmodule

// File: rtl/mbp_gap_timer.sv
module mbp_gap_timer #(
  parameter int POLL_GAP = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);

  localparam int GAP_W = (POLL_GAP > 1) ? $clog2(POLL_GAP + 1) : 1;
  localparam logic [GAP_W-1:0] LOAD_V = GAP_W'(POLL_GAP - 1);

  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= LOAD_V;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/mbp_attempt_ctr.sv
module mbp_attempt_ctr #(
  parameter int MAX_POLLS = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic last_o
);

  localparam int CNT_W = (MAX_POLLS > 2) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(MAX_POLLS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (step_i && (cnt_q != LAST_V)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == LAST_V);

endmodule

// File: rtl/mbox_rsp_poller.sv
module mbox_rsp_poller
  import mbp_pkg::*;
#(
  parameter int MAX_POLLS = 20000,
  parameter int POLL_GAP  = 250000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [2:0]  exp_type_i,
  input  logic [2:0]  exp_ver_i,
  input  logic        reset_ok_i,
  output logic        rd_valid_o,
  input  logic        rd_ready_i,
  input  logic        rsp_valid_i,
  input  logic [31:0] rsp_data_i,
  output logic        rsp_ready_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [1:0]  result_o
);

  mbp_state_e        state_q, state_d;
  logic [TYPE_W-1:0] exp_type_q;
  logic [VER_W-1:0]  exp_ver_q;
  logic              rok_q;
  logic              done_q;
  mbp_result_e       result_q;

  logic        accept;
  logic        rsp_fire;
  logic        reset_hit;
  logic        owner_free;
  logic        last_try;
  logic        finish;
  logic        gap_load;
  logic        gap_over;
  mbp_result_e verdict;
  mbp_result_e final_code;
  mbp_hdr_t    hdr;

  assign accept   = start_i && (state_q == ST_IDLE);
  assign rsp_fire = rsp_valid_i && rsp_ready_o;
  assign hdr      = mbp_hdr_t'(rsp_data_i);

  assign reset_hit  = rok_q && (&rsp_data_i);
  assign owner_free = !hdr.owner;
  assign finish     = reset_hit || owner_free || last_try;
  assign gap_load   = rsp_fire && !finish;

  mbp_hdr_check u_check (
    .word_i     (rsp_data_i),
    .exp_type_i (exp_type_q),
    .exp_ver_i  (exp_ver_q),
    .verdict_o  (verdict)
  );

  mbp_gap_timer #(.POLL_GAP(POLL_GAP)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (gap_load),
    .expired_o (gap_over)
  );

  mbp_attempt_ctr #(.MAX_POLLS(MAX_POLLS)) u_tries (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .step_i  (gap_load),
    .last_o  (last_try)
  );

  always_comb begin
    if (reset_hit) begin
      final_code = RES_OK;
    end else if (owner_free) begin
      final_code = verdict;
    end else begin
      final_code = RES_TIMEOUT;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_ISSUE;
      ST_ISSUE: if (rd_ready_i) state_d = ST_WAIT;
      ST_WAIT:  if (rsp_valid_i) state_d = finish ? ST_IDLE : ST_GAP;
      ST_GAP:   if (gap_over) state_d = ST_ISSUE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      exp_type_q <= '0;
      exp_ver_q  <= '0;
      rok_q      <= 1'b0;
      done_q     <= 1'b0;
      result_q   <= RES_OK;
    end else begin
      state_q <= state_d;
      done_q  <= rsp_fire && finish;
      if (accept) begin
        exp_type_q <= exp_type_i;
        exp_ver_q  <= exp_ver_i;
        rok_q      <= reset_ok_i;
      end
      if (rsp_fire && finish) begin
        result_q <= final_code;
      end
    end
  end

  assign rd_valid_o  = (state_q == ST_ISSUE);
  assign rsp_ready_o = (state_q == ST_WAIT);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign result_o    = result_q;

endmodule

// File: rtl/mbp_checker.sv
module mbp_checker #(
  parameter int MAX_POLLS = 20000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        rd_valid_o,
  input logic        rd_ready_i,
  input logic        rsp_valid_i,
  input logic [31:0] rsp_data_i,
  input logic        rsp_ready_o,
  input logic        busy_o,
  input logic        done_o,
  input logic [1:0]  result_o,
  input logic [2:0]  exp_type_q,
  input logic [2:0]  exp_ver_q,
  input logic        rok_q
);

  localparam int RW = $clog2(MAX_POLLS + 2);
  localparam logic [RW-1:0] MAX_V = RW'(MAX_POLLS);

  logic [RW-1:0] reads_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      reads_q <= '0;
    end else if (start_i && !busy_o) begin
      reads_q <= '0;
    end else if (rd_valid_o && rd_ready_i) begin
      reads_q <= reads_q + 1'b1;
    end
  end

  a_r1_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(exp_type_q) && $stable(exp_ver_q) && $stable(rok_q));

  a_r2_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o);

  a_r2_one_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_o && rsp_ready_o));

  a_r3_free_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && rsp_ready_o && !rsp_data_i[31] |=> done_o);

  a_r4_reset_word_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && rsp_ready_o && rok_q && (&rsp_data_i) |=> done_o && (result_o == 2'd0));

  a_r8_read_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reads_q <= MAX_V);

  a_r8_timeout_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (result_o == 2'd1) |-> reads_q == MAX_V);

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(rsp_valid_i && rsp_ready_o));

endmodule

bind mbox_rsp_poller mbp_checker #(.MAX_POLLS(MAX_POLLS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .rd_valid_o  (rd_valid_o),
  .rd_ready_i  (rd_ready_i),
  .rsp_valid_i (rsp_valid_i),
  .rsp_data_i  (rsp_data_i),
  .rsp_ready_o (rsp_ready_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .result_o    (result_o),
  .exp_type_q  (exp_type_q),
  .exp_ver_q   (exp_ver_q),
  .rok_q       (rok_q)
);

// File: tb/mbox_rsp_poller_tb_top.sv
`timescale 1ns/1ps
module mbox_rsp_poller_tb_top;

  localparam int MAXP = 5;
  localparam int GAP  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  exp_type_i = '0;
  logic [2:0]  exp_ver_i = '0;
  logic        reset_ok_i = 1'b0;
  logic        rd_valid_o;
  logic        rd_ready_i = 1'b0;
  logic        rsp_valid_i = 1'b0;
  logic [31:0] rsp_data_i = 32'hFFFF_FFFF;
  logic        rsp_ready_o;
  logic        busy_o;
  logic        done_o;
  logic [1:0]  result_o;

  always #2 clk = ~clk;

  mbox_rsp_poller #(.MAX_POLLS(MAXP), .POLL_GAP(GAP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .exp_type_i(exp_type_i),
    .exp_ver_i(exp_ver_i), .reset_ok_i(reset_ok_i), .rd_valid_o(rd_valid_o),
    .rd_ready_i(rd_ready_i), .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
    .rsp_ready_o(rsp_ready_o), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  int     n_run = 0;
  int     n_bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory-side responder model
  logic [31:0] scr [0:7];
  int     case_id = 0;
  int     seen_id = 0;
  int     idx = 0;
  int     reads = 0;
  int     lat = 0;
  bit     pending = 0;
  bit     gap_wait = 0;
  longint acc_cyc = 0;

  always @(negedge clk) begin
    if (case_id != seen_id) begin
      seen_id = case_id; idx = 0; reads = 0; pending = 0; gap_wait = 0;
    end
    if (gap_wait && rd_valid_o) begin
      check(cyc - acc_cyc == GAP + 1, "R7", "idle gap before next read",
            cyc - acc_cyc - 1, GAP);
      gap_wait = 0;
    end
    rsp_valid_i = 1'b0;
    rsp_data_i  = 32'hFFFF_FFFF;
    if (pending) begin
      if (lat == 0) begin
        rsp_valid_i = 1'b1;
        rsp_data_i  = scr[idx];
        if (rsp_ready_o) begin
          idx++; pending = 0; acc_cyc = cyc; gap_wait = 1;
        end
      end else begin
        lat--;
      end
    end
    rd_ready_i = ($urandom % 3) != 0;
    if (rd_valid_o && rd_ready_i) begin
      reads++; pending = 1; lat = $urandom % 3;
    end
  end

  function automatic void model(input logic [2:0] et, input logic [2:0] ev, input bit rok,
                                output int code, output int nr);
    code = 1; nr = MAXP;
    for (int k = 0; k < MAXP; k++) begin
      logic [31:0] w;
      w = scr[k];
      if (rok && w == 32'hFFFF_FFFF) begin code = 0; nr = k + 1; return; end
      if (!w[31]) begin
        nr = k + 1;
        if (w[2:0] != et || w[5:3] > ev || !w[7]) code = 2;
        else if (w[15:8] != 8'd0) code = 3;
        else code = 0;
        return;
      end
    end
  endfunction

  function automatic logic [31:0] busy_word();
    logic [31:0] w;
    w = {1'b1, 31'($urandom)};
    if (&w) w[0] = 1'b0;
    return w;
  endfunction

  function automatic logic [31:0] reply(input logic [2:0] t, input logic [2:0] v,
                                        input bit dir, input logic [7:0] st);
    logic [31:0] w;
    w = $urandom;
    w[31] = 1'b0; w[15:8] = st; w[7] = dir; w[5:3] = v; w[2:0] = t;
    return w;
  endfunction

  task automatic run_case(input logic [2:0] et, input logic [2:0] ev, input bit rok,
                          input bit inject, input string req);
    int code, nr, w;
    longint last_acc;
    model(et, ev, rok, code, nr);
    case_id++;
    @(negedge clk); @(negedge clk);
    start_i = 1'b1; exp_type_i = et; exp_ver_i = ev; reset_ok_i = rok;
    @(negedge clk);
    start_i = 1'b0; exp_type_i = ~et; exp_ver_i = 3'($urandom); reset_ok_i = ~rok;
    check(busy_o == 1'b1, "R1", "busy after start", busy_o, 1);
    if (inject) begin
      @(negedge clk);
      start_i = 1'b1; exp_type_i = ~et; exp_ver_i = 3'd0; reset_ok_i = ~rok;
      @(negedge clk);
      start_i = 1'b0;
    end
    w = 0;
    while (!done_o && w < 2000) begin @(negedge clk); w++; end
    last_acc = acc_cyc;
    check(done_o == 1'b1, req, "done seen", done_o, 1);
    check(result_o == 2'(code), req, "result code", result_o, code);
    check(reads == nr, "R8", "reads issued", reads, nr);
    check(cyc == last_acc + 1, "R9", "done one cycle after last reply", cyc - last_acc, 1);
    check(busy_o == 1'b0, "R9", "idle with done", busy_o, 0);
    @(negedge clk);
    check(done_o == 1'b0, "R9", "done is one cycle", done_o, 0);
    check(result_o == 2'(code), "R9", "result held", result_o, code);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < 8; k++) scr[k] = 32'h8000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(busy_o == 0 && done_o == 0 && rd_valid_o == 0 && rsp_ready_o == 0,
          "R10", "idle outputs", {busy_o, done_o, rd_valid_o, rsp_ready_o}, 0);
    check(result_o == 2'd0, "R10", "result after reset", result_o, 0);

    // R3, R6: immediate clean reply
    for (int k = 0; k < 8; k++) scr[k] = busy_word();
    scr[0] = reply(3'd2, 3'd1, 1'b1, 8'd0);
    run_case(3'd2, 3'd1, 1'b0, 1'b0, "R3");
    // R5: older version accepted
    scr[0] = reply(3'd1, 3'd0, 1'b1, 8'd0);
    run_case(3'd1, 3'd4, 1'b0, 1'b0, "R5");
    // R5: newer version rejected
    scr[0] = reply(3'd1, 3'd5, 1'b1, 8'd0);
    run_case(3'd1, 3'd4, 1'b0, 1'b0, "R5");
    // R5: type mismatch
    scr[0] = busy_word(); scr[1] = reply(3'd6, 3'd0, 1'b1, 8'd0);
    run_case(3'd2, 3'd0, 1'b0, 1'b0, "R5");
    // R5: direction still request
    scr[0] = reply(3'd2, 3'd0, 1'b0, 8'd0);
    run_case(3'd2, 3'd0, 1'b0, 1'b0, "R5");
    // R6: failing status
    scr[0] = reply(3'd2, 3'd0, 1'b1, 8'h41);
    run_case(3'd2, 3'd0, 1'b0, 1'b0, "R6");
    // R8: timeout
    for (int k = 0; k < 8; k++) scr[k] = busy_word();
    run_case(3'd1, 3'd0, 1'b0, 1'b0, "R8");
    // R8: reply on the very last attempt
    scr[MAXP-1] = reply(3'd1, 3'd0, 1'b1, 8'd0);
    run_case(3'd1, 3'd0, 1'b0, 1'b0, "R8");
    // R4: all-ones with reset expected
    scr[0] = busy_word(); scr[1] = 32'hFFFF_FFFF;
    run_case(3'd3, 3'd0, 1'b1, 1'b0, "R4");
    // R4: all-ones without reset expected keeps polling
    scr[2] = reply(3'd3, 3'd0, 1'b1, 8'd0);
    run_case(3'd3, 3'd0, 1'b0, 1'b0, "R4");
    // R1: start while busy ignored
    for (int k = 0; k < 8; k++) scr[k] = busy_word();
    scr[3] = reply(3'd5, 3'd2, 1'b1, 8'd0);
    run_case(3'd5, 3'd2, 1'b0, 1'b1, "R1");

    // Random mix (R2, R3, R4, R5, R6, R7, R8)
    for (int n = 0; n < 60; n++) begin
      logic [2:0] et, ev;
      bit rok;
      et = 3'($urandom); ev = 3'($urandom); rok = $urandom % 2;
      for (int k = 0; k < 8; k++) begin
        int pick;
        pick = $urandom % 20;
        if (pick < 12) scr[k] = busy_word();
        else if (pick < 15) scr[k] = 32'hFFFF_FFFF;
        else scr[k] = reply(($urandom % 4 == 0) ? 3'($urandom) : et, 3'($urandom),
                            ($urandom % 5) != 0,
                            ($urandom % 3 == 0) ? 8'($urandom | 1) : 8'd0);
      end
      run_case(et, ev, rok, 1'b0, "R2");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_run++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

endmodule